// File: doc/BRIEF.md
# Row Activation Disturbance Tracker

This block watches the activate commands sent to one DRAM bank and keeps a running count of how often each recently opened row has been activated in the current refresh window. Each activation disturbs the cells in the two rows physically next to the opened row. When one row collects enough activations to put its neighbours at risk, the tracker queues a targeted refresh for each of those neighbours. It does not refresh the aggressor row itself.

Only a small fully associative table of rows is tracked. A new row takes a free slot if one exists. If the table is full, the new row replaces the entry with the smallest count, so the most active rows stay in the table. The retention-window pulse clears every counter. Queued refreshes leave through a valid/ready stream. A request stays on the port, unchanged, until the refresh path accepts it. Back-pressure fills the small request queue. A request that finds no room is dropped, and a sticky flag records the loss.

The activate input has no ready signal, because the tracker only monitors commands and never stalls them. The consumer of the refresh stream sets the back-pressure and may hold `ref_ready` low for as long as it likes. The only cost of doing so is the risk of overflow.

Top module: `rowhammer_tracker`

## Requirements
- R1: After reset, `ref_valid` and `overflow` are low and no row has any activations counted.
- R2: An activation of a row already in the table adds one to its count. When a row's count reaches `THRESH` (default 262144), neighbour refreshes are triggered for that row.
- R3: A trigger queues the row one below the aggressor first and the row one above it second. The aggressor's own address is never queued.
- R4: Neighbours are clipped at the array edges. Row 0 queues only row 1, and row `2**ROW_W-1` queues only the row below it.
- R5: The trigger leaves the aggressor's count at zero, so another `THRESH` activations are needed before it triggers again.
- R6: A `window_clear` pulse empties the table. An activation presented in the same cycle as `window_clear` is ignored.
- R7: A row that is not in the table takes a free entry with a count of one.
- R8: When the table is full, a new row replaces the entry with the smallest count (the lowest index wins a tie). The new entry starts at that smallest count plus one.
- R9: A request stays on `ref_row` with `ref_valid` high, unchanged, until `ref_ready` is sampled high. Requests leave in the order they were queued.
- R10: A neighbour that finds the queue full is dropped and sets `overflow`. `overflow` stays high until the next `window_clear`. A request popped in the same cycle does not make room for that cycle's neighbours.
- R11: The first request of a trigger appears on the stream in the cycle after the triggering activation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| act_valid | input | 1 | An activate command is issued to this bank in this cycle |
| act_row | input | ROW_W | Row address of the activate |
| window_clear | input | 1 | Pulse at the end of each retention window |
| ref_valid | output | 1 | A neighbour refresh request is offered |
| ref_ready | input | 1 | The refresh path accepts the offered request |
| ref_row | output | ROW_W | Row to refresh |
| overflow | output | 1 | Sticky: a neighbour request was dropped this window |

## Verification
A wrong count or a wrong replacement choice inside the table stays hidden until a row reaches `THRESH`. The error then shows on the stream as a request that comes one or more activations early or late, or that does not come at all. For this reason the checks count the exact activation at which `ref_valid` rises. An error in the queue shows within a cycle or two of a pop, as a row out of order, a repeated row or a missing row. An error in clipping or in the neighbour arithmetic shows directly as a wrong value on `ref_row`.

// File: rtl/rht_pkg.sv
package rht_pkg;
  // How an incoming activation is placed in the table
  typedef enum logic [1:0] {
    SLOT_HIT   = 2'd0,
    SLOT_FREE  = 2'd1,
    SLOT_EVICT = 2'd2
  } slot_kind_e;
endpackage

// File: rtl/rht_table.sv
module rht_table
  import rht_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ROW_W   = 17,
  parameter int THRESH  = 262144,
  parameter int CNT_W   = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_valid,
  input  logic [ROW_W-1:0] act_row,
  input  logic             win_clear,
  output logic             trig,
  output logic [ROW_W-1:0] trig_row
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]   ent_vld;
  logic [ROW_W-1:0]     ent_row [ENTRIES];
  logic [CNT_W-1:0]     ent_cnt [ENTRIES];

  logic                 hit, has_free;
  logic [IDX_W-1:0]     hit_idx, free_idx, min_idx, tgt_idx;
  logic [CNT_W-1:0]     min_cnt, base_cnt, next_cnt;
  slot_kind_e           kind;

  // match and free-slot search
  always_comb begin
    hit      = 1'b0;
    hit_idx  = '0;
    has_free = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (ent_vld[i] && ent_row[i] == act_row) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
      if (!ent_vld[i]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  // smallest-count search, lowest index on a tie
  always_comb begin
    min_idx = '0;
    min_cnt = ent_cnt[0];
    for (int i = 1; i < ENTRIES; i++) begin
      if (ent_cnt[i] < min_cnt) begin
        min_cnt = ent_cnt[i];
        min_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (hit)           kind = SLOT_HIT;
    else if (has_free) kind = SLOT_FREE;
    else               kind = SLOT_EVICT;
    case (kind)
      SLOT_HIT:  begin base_cnt = ent_cnt[hit_idx]; tgt_idx = hit_idx;  end
      SLOT_FREE: begin base_cnt = '0;               tgt_idx = free_idx; end
      default:   begin base_cnt = min_cnt;          tgt_idx = min_idx;  end
    endcase
    next_cnt = base_cnt + CNT_W'(1);
  end

  assign trig     = act_valid && !win_clear && (next_cnt >= CNT_W'(THRESH));
  assign trig_row = act_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_vld <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        ent_row[i] <= '0;
        ent_cnt[i] <= '0;
      end
    end else if (win_clear) begin
      ent_vld <= '0;
      for (int i = 0; i < ENTRIES; i++) ent_cnt[i] <= '0;
    end else if (act_valid) begin
      ent_vld[tgt_idx] <= 1'b1;
      ent_row[tgt_idx] <= act_row;
      ent_cnt[tgt_idx] <= trig ? '0 : next_cnt;
    end
  end
endmodule

// File: rtl/rht_neighbors.sv
module rht_neighbors #(
  parameter int ROW_W = 17
) (
  input  logic             trig,
  input  logic [ROW_W-1:0] row,
  output logic             lo_valid,
  output logic [ROW_W-1:0] lo_row,
  output logic             hi_valid,
  output logic [ROW_W-1:0] hi_row
);
  localparam logic [ROW_W-1:0] ROW_MAX = '1;

  assign lo_valid = trig && (row != '0);
  assign hi_valid = trig && (row != ROW_MAX);
  assign lo_row   = row - ROW_W'(1);
  assign hi_row   = row + ROW_W'(1);
endmodule

// File: rtl/rht_fifo.sv
module rht_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         a_valid,
  input  logic [W-1:0] a_data,
  input  logic         b_valid,
  input  logic [W-1:0] b_data,
  output logic         dropped,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr, wr_ptr_n;
  logic [CW-1:0] count, space;
  logic [1:0]    n_req, n_acc;
  logic [W-1:0]  first_d;
  logic          pop;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign space    = CW'(DEPTH) - count;
  assign n_req    = {1'b0, a_valid} + {1'b0, b_valid};
  assign n_acc    = (CW'(n_req) > space) ? space[1:0] : n_req;
  assign dropped  = CW'(n_req) > space;
  assign first_d  = a_valid ? a_data : b_data;
  assign wr_ptr_n = inc(wr_ptr);
  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (n_acc != 2'd0) mem[wr_ptr]   <= first_d;
      if (n_acc == 2'd2) mem[wr_ptr_n] <= b_data;
      case (n_acc)
        2'd1:    wr_ptr <= wr_ptr_n;
        2'd2:    wr_ptr <= inc(wr_ptr_n);
        default: wr_ptr <= wr_ptr;
      endcase
      if (pop) rd_ptr <= inc(rd_ptr);
      count <= count + CW'(n_acc) - CW'(pop);
    end
  end
endmodule

// File: rtl/rowhammer_tracker.sv
module rowhammer_tracker #(
  parameter int ROW_W      = 17,
  parameter int ENTRIES    = 16,
  parameter int THRESH     = 262144,
  parameter int FIFO_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_valid,
  input  logic [ROW_W-1:0] act_row,
  input  logic             window_clear,
  output logic             ref_valid,
  input  logic             ref_ready,
  output logic [ROW_W-1:0] ref_row,
  output logic             overflow
);
  localparam int CNT_W = $clog2(THRESH + 1);

  logic             trig;
  logic [ROW_W-1:0] trig_row;
  logic             lo_v, hi_v, dropped;
  logic [ROW_W-1:0] lo_r, hi_r;

  rht_table #(
    .ENTRIES(ENTRIES), .ROW_W(ROW_W), .THRESH(THRESH), .CNT_W(CNT_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_row(act_row),
    .win_clear(window_clear), .trig(trig), .trig_row(trig_row)
  );

  rht_neighbors #(.ROW_W(ROW_W)) u_nbr (
    .trig(trig), .row(trig_row),
    .lo_valid(lo_v), .lo_row(lo_r), .hi_valid(hi_v), .hi_row(hi_r)
  );

  rht_fifo #(.DEPTH(FIFO_DEPTH), .W(ROW_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .a_valid(lo_v), .a_data(lo_r), .b_valid(hi_v), .b_data(hi_r),
    .dropped(dropped),
    .out_valid(ref_valid), .out_data(ref_row), .out_ready(ref_ready)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            overflow <= 1'b0;
    else if (window_clear) overflow <= 1'b0;
    else if (dropped)      overflow <= 1'b1;
  end
endmodule

// File: rtl/rht_checker.sv
module rht_checker #(
  parameter int ROW_W = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             act_valid,
  input logic             window_clear,
  input logic             ref_valid,
  input logic             ref_ready,
  input logic [ROW_W-1:0] ref_row,
  input logic             overflow
);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid && !ref_ready |=> ref_valid && $stable(ref_row));

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !window_clear |=> overflow);

  p_ovf_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    window_clear |=> !overflow);

  p_req_after_act_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_valid) |-> $past(act_valid && !window_clear));

  p_ovf_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(act_valid && !window_clear));
endmodule

bind rowhammer_tracker rht_checker #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .window_clear(window_clear),
  .ref_valid(ref_valid), .ref_ready(ref_ready), .ref_row(ref_row),
  .overflow(overflow)
);

// File: tb/sim_rowhammer_tracker.sv
module sim_rowhammer_tracker;
  localparam int RW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          act_valid = 1'b0;
  logic [RW-1:0] act_row = '0;
  logic          window_clear = 1'b0;
  logic          ref_ready = 1'b0;
  logic          ref_valid, overflow;
  logic [RW-1:0] ref_row;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  rowhammer_tracker #(.ROW_W(RW), .ENTRIES(4), .THRESH(4), .FIFO_DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_row(act_row),
    .window_clear(window_clear), .ref_valid(ref_valid), .ref_ready(ref_ready),
    .ref_row(ref_row), .overflow(overflow)
  );

  typedef struct packed {
    logic [RW-1:0] row;
    logic          ev;
    logic [RW-1:0] erow;
  } vec_t;

  // ref_ready held low; queue fills 4,6 then 1 then 14
  localparam vec_t VEC [12] = '{
    '{4'd5, 1'b0, 4'd0}, '{4'd5, 1'b0, 4'd0}, '{4'd5, 1'b0, 4'd0},
    '{4'd5, 1'b1, 4'd4},
    '{4'd0, 1'b1, 4'd4}, '{4'd0, 1'b1, 4'd4}, '{4'd0, 1'b1, 4'd4},
    '{4'd0, 1'b1, 4'd4},
    '{4'd15, 1'b1, 4'd4}, '{4'd15, 1'b1, 4'd4}, '{4'd15, 1'b1, 4'd4},
    '{4'd15, 1'b1, 4'd4}
  };

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic act(input logic [RW-1:0] r);
    @(negedge clk);
    act_valid = 1'b1;
    act_row   = r;
    @(negedge clk);
    act_valid = 1'b0;
  endtask

  task automatic act_n(input logic [RW-1:0] r, input int n);
    for (int i = 0; i < n; i++) act(r);
  endtask

  task automatic clear_win();
    @(negedge clk);
    window_clear = 1'b1;
    @(negedge clk);
    window_clear = 1'b0;
  endtask

  // check the head, then accept it
  task automatic pop_chk(input string req, input int exp_row);
    chk(req, int'(ref_valid), 1);
    chk(req, int'(ref_row), exp_row);
    ref_ready = 1'b1;
    @(negedge clk);
    ref_ready = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid", int'(ref_valid), 0);
    chk("R1 overflow", int'(overflow), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", int'(ref_valid), 0);

    // R2 R3 R4 R7 R11: vector walk
    foreach (VEC[i]) begin
      act(VEC[i].row);
      chk($sformatf("R2/R11 vec%0d valid", i), int'(ref_valid), int'(VEC[i].ev));
      if (VEC[i].ev) chk($sformatf("R3 vec%0d head", i), int'(ref_row), int'(VEC[i].erow));
    end
    chk("R10 exactly full no overflow", int'(overflow), 0);

    // R9: head held while not ready
    repeat (3) @(negedge clk);
    chk("R9 held valid", int'(ref_valid), 1);
    chk("R9 held row", int'(ref_row), 4);
    pop_chk("R3 lower first", 4);
    pop_chk("R3 upper second", 6);
    pop_chk("R4 row0 clip", 1);
    pop_chk("R4 rowmax clip", 14);
    chk("R9 drained", int'(ref_valid), 0);

    // R5: counter restarts at zero after trigger
    act_n(4'd5, 3);
    chk("R5 no early retrigger", int'(ref_valid), 0);
    act(4'd5);
    chk("R5 retrigger", int'(ref_valid), 1);
    pop_chk("R5 lower", 4);
    pop_chk("R5 upper", 6);

    // R6: window clear wipes counts; same-cycle activate ignored
    clear_win();
    act_n(4'd7, 3);
    clear_win();
    act_n(4'd7, 3);
    chk("R6 cleared counts", int'(ref_valid), 0);
    clear_win();
    @(negedge clk);
    window_clear = 1'b1; act_valid = 1'b1; act_row = 4'd7;
    @(negedge clk);
    window_clear = 1'b0; act_valid = 1'b0;
    act_n(4'd7, 3);
    chk("R6 same-cycle act ignored", int'(ref_valid), 0);
    act(4'd7);
    chk("R6 count after clear", int'(ref_valid), 1);
    pop_chk("R6 lower", 6);
    pop_chk("R6 upper", 8);

    // R7 R8: replacement of smallest-count entry
    clear_win();
    act_n(4'd1, 3);
    act_n(4'd2, 1);
    act_n(4'd3, 2);
    act_n(4'd8, 2);
    act(4'd9);          // evicts row 2 (count 1), starts at 2
    act(4'd9);
    chk("R8 evict start min+1 (no early)", int'(ref_valid), 0);
    act(4'd9);
    chk("R8 evict start min+1 trigger", int'(ref_valid), 1);
    act(4'd1);          // row 1 kept its count of 3
    pop_chk("R8 lower", 8);
    pop_chk("R8 upper", 10);
    pop_chk("R7 kept entry lower", 0);
    pop_chk("R7 kept entry upper", 2);

    // R10: overflow when queue is full
    clear_win();
    act_n(4'd5, 4);
    act_n(4'd10, 4);
    chk("R10 full no overflow", int'(overflow), 0);
    act_n(4'd12, 4);
    chk("R10 overflow set", int'(overflow), 1);
    @(negedge clk);
    chk("R10 overflow sticky", int'(overflow), 1);
    pop_chk("R10 q0", 4);
    pop_chk("R10 q1", 6);
    pop_chk("R10 q2", 9);
    pop_chk("R10 q3", 11);
    chk("R10 dropped not queued", int'(ref_valid), 0);
    chk("R10 sticky after drain", int'(overflow), 1);
    clear_win();
    chk("R10 cleared by window", int'(overflow), 0);

    summary();
  end
endmodule